// File: doc/BRIEF.md
# Way-Predicted Set-Associative Lookup

This block is the lookup stage of a small level-one cache with two or four ways per set. Each set keeps a small prediction naming the way most likely to hold the requested line. When a request arrives, the prediction steers the read-data multiplexer right away, while the tag comparators run in parallel. If the predicted way turns out to hold the line, the response is ready one cycle after acceptance, which is as fast as a direct-mapped cache. If another way holds it, or no way does, the block takes a second cycle. In that cycle it compares every way again and answers. After a hit in a way other than the predicted one, it retrains the prediction for that set.

Requests use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops for exactly one cycle after any accepted request that does not hit in its predicted way. Upstream logic must hold its next request during that cycle. Responses are a one-cycle `rsp_valid` pulse and cannot be back-pressured.

A plain fill port installs a line into the storage, which is a set of internal registers. Refill sequencing, writes and coherence belong to other blocks.

Top module: `wp_lookup`

## Requirements
- R1: After reset, every way of every set is invalid, every set predicts way 0, `req_ready` is high and `rsp_valid` is low.
- R2: The request address is split into an index, taken from bits `[IDX_W-1:0]`, and a tag, taken from the bits above the index.
- R3: If the predicted way of the indexed set is valid and its tag is equal to the request tag, `rsp_valid` is high in the first cycle after acceptance. In that cycle `rsp_hit`=1, `rsp_fast`=1 and `rsp_data` is the data of that way.
- R4: If a valid way other than the predicted one has the same tag as the request, `req_ready` and `rsp_valid` are low in the first cycle after acceptance. In the second cycle `rsp_valid`=1, `rsp_hit`=1, `rsp_fast`=0 and `rsp_data` is the data of the matching way.
- R5: After an R4 hit, the set's prediction holds the way number of the matching way. The way number is a log2(WAYS)-bit index, 0 to WAYS-1. A repeat of the same request is therefore an R3 hit.
- R6: If no valid way has the same tag as the request, the response comes in the second cycle with `rsp_hit`=0, `rsp_fast`=0 and `rsp_data`=0, and the set's prediction is left unchanged.
- R7: An invalid way never matches, even when its stored tag is equal to the request tag.
- R8: A fill with `fill_en`=1 writes the tag and data of way `fill_way` in set `fill_idx` and marks that way valid. It changes no other line and no prediction.
- R9: `req_ready` is low only in the single cycle after an accepted request that does not hit its predicted way. Each accepted request produces exactly one response, so predicted hits can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Lookup address: tag above index |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Line present |
| rsp_fast | output | 1 | Hit came from the predicted way in one cycle |
| rsp_data | output | DATA_W | Data of the hit line, zero on a miss |
| fill_en | input | 1 | Install a line |
| fill_way | input | WAY_W | Way to install into |
| fill_idx | input | IDX_W | Set to install into |
| fill_tag | input | TAG_W | Tag of installed line |
| fill_data | input | DATA_W | Data of installed line |

## Verification
A corrupted prediction does not show up as wrong data. It shows up on the next access to that set as a slow hit where a fast one was due: `req_ready` drops and `rsp_fast` is low one cycle after acceptance. A stuck or corrupted valid bit or tag shows up on the first lookup of that line, as a miss in place of a hit or as a hit with nonzero data where zero was due. A faulty update rule shows up only on the second access to a line, so the sweeps repeat every lookup and then follow it with misses aimed at sets that have already been trained.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Sequencing of the lookup: idle accepts, recheck is the slow second cycle.
  typedef enum logic {
    LK_IDLE    = 1'b0,
    LK_RECHECK = 1'b1
  } lk_state_e;
endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_en,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WAYS-1:0]              rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic              wr_this;

    assign wr_this = fill_en && (fill_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else if (wr_this) vld_q[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_this) begin
        tag_q[fill_idx] <= fill_tag;
        dat_q[fill_idx] <= fill_data;
      end
    end

    assign rd_valid[w] = vld_q[rd_idx];
    assign rd_tag[w]   = tag_q[rd_idx];
    assign rd_data[w]  = dat_q[rd_idx];
  end
endmodule

// File: rtl/wp_way_match.sv
module wp_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           cmp_tag,
  output logic [WAYS-1:0]            match,
  output logic                       any_match,
  output logic [WAY_W-1:0]           match_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == cmp_tag);
  end

  assign any_match = |match;

  always_comb begin
    match_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) match_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wp_predictor.sv
module wp_predictor #(
  parameter int WAYS = 4,
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] rd_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way
);
  logic [WAY_W-1:0] guess_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) guess_q[s] <= '0;
    end else if (upd_en) begin
      guess_q[upd_idx] <= upd_way;
    end
  end

  assign rd_way = guess_q[rd_idx];
endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
  import wp_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fast,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  lk_state_e                  state_q;
  logic [IDX_W-1:0]           held_idx_q;
  logic [TAG_W-1:0]           held_tag_q;

  logic [IDX_W-1:0]           look_idx;
  logic [TAG_W-1:0]           look_tag;
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0][DATA_W-1:0] set_data;
  logic [WAYS-1:0]            match;
  logic                       any_match;
  logic [WAY_W-1:0]           match_way;
  logic [WAY_W-1:0]           guess_way;
  logic                       accept;
  logic                       guess_hit;
  logic                       retrain;

  // In the recheck cycle the stored request drives the arrays.
  assign look_idx = (state_q == LK_RECHECK) ? held_idx_q : req_addr[IDX_W-1:0];
  assign look_tag = (state_q == LK_RECHECK) ? held_tag_q : req_addr[ADDR_W-1:IDX_W];

  wp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_way(fill_way), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_data(fill_data),
    .rd_idx(look_idx), .rd_valid(set_valid), .rd_tag(set_tag), .rd_data(set_data)
  );

  wp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_valid(set_valid), .way_tag(set_tag), .cmp_tag(look_tag),
    .match(match), .any_match(any_match), .match_way(match_way)
  );

  wp_predictor #(.WAYS(WAYS), .SETS(SETS)) u_pred (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_way(guess_way),
    .upd_en(retrain), .upd_idx(held_idx_q), .upd_way(match_way)
  );

  assign req_ready = (state_q == LK_IDLE);
  assign accept    = req_valid && req_ready;
  // The guessed way picks the data before its compare is needed.
  assign guess_hit = match[guess_way];
  assign retrain   = (state_q == LK_RECHECK) && any_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LK_IDLE;
      held_idx_q <= '0;
      held_tag_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fast   <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (state_q == LK_RECHECK) begin
        state_q   <= LK_IDLE;
        rsp_valid <= 1'b1;
        rsp_hit   <= any_match;
        rsp_fast  <= 1'b0;
        rsp_data  <= any_match ? set_data[match_way] : '0;
      end else if (accept) begin
        if (guess_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_fast  <= 1'b1;
          rsp_data  <= set_data[guess_way];
        end else begin
          state_q    <= LK_RECHECK;
          held_idx_q <= req_addr[IDX_W-1:0];
          held_tag_q <= req_addr[ADDR_W-1:IDX_W];
        end
      end
    end
  end
endmodule

// File: rtl/wp_lookup_chk.sv
module wp_lookup_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_fast,
  input logic [DATA_W-1:0] rsp_data
);
  // R9
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));

  // R9
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  // R4
  stall_then_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (rsp_valid && !rsp_fast));

  // R3
  fast_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fast) |-> rsp_hit);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && !rsp_fast));

  // R9
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));
endmodule

bind wp_lookup wp_lookup_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fast(rsp_fast), .rsp_data(rsp_data)
);

// File: tb/wp_lookup_tb.sv
module wp_lookup_tb;
  localparam int WAYS = 4, SETS = 4, TAG_W = 4, DATA_W = 8;
  localparam int IDX_W = 2, WAY_W = 2, ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_fast;
  logic [DATA_W-1:0] rsp_data;
  logic fill_en = 1'b0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit   m_vld [SETS][WAYS];
  int   m_tag [SETS][WAYS];
  int   m_dat [SETS][WAYS];
  int   m_pred [SETS];

  always #4 clk = ~clk;

  wp_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fast(rsp_fast), .rsp_data(rsp_data), .fill_en(fill_en),
    .fill_way(fill_way), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data)
  );

  function automatic int line_data(int s, int w, int t);
    return (s * 37 + w * 11 + t * 3 + 5) % 256;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_fill(int s, int w, int t, int d);
    @(negedge clk);
    fill_en = 1'b1; fill_way = WAY_W'(w); fill_idx = IDX_W'(s);
    fill_tag = TAG_W'(t); fill_data = DATA_W'(d);
    @(negedge clk);
    fill_en = 1'b0;
    m_vld[s][w] = 1'b1; m_tag[s][w] = t; m_dat[s][w] = d;
  endtask

  // One lookup with expectation taken from the bench model (R2 address split).
  task automatic do_lookup(int s, int t);
    int hw = -1;
    bit fast;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
    fast = (hw >= 0) && (hw == m_pred[s]);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = ADDR_W'((t << IDX_W) | s);
    @(negedge clk);
    req_valid = 1'b0;
    if (fast) begin
      chk(rsp_valid && rsp_hit && rsp_fast, "R3 fast hit flags",
          int'({rsp_valid, rsp_hit, rsp_fast}), 7);
      chk(int'(rsp_data) == m_dat[s][hw], "R3 fast hit data", int'(rsp_data), m_dat[s][hw]);
    end else begin
      chk(!rsp_valid && !req_ready, "R4 stall cycle", int'({rsp_valid, req_ready}), 0);
      @(negedge clk);
      if (hw >= 0) begin
        chk(rsp_valid && rsp_hit && !rsp_fast, "R4 slow hit flags",
            int'({rsp_valid, rsp_hit, rsp_fast}), 6);
        chk(int'(rsp_data) == m_dat[s][hw], "R4 slow hit data", int'(rsp_data), m_dat[s][hw]);
        m_pred[s] = hw;
      end else begin
        chk(rsp_valid && !rsp_hit && !rsp_fast, "R6 miss flags",
            int'({rsp_valid, rsp_hit, rsp_fast}), 4);
        chk(rsp_data == '0, "R6 miss data", int'(rsp_data), 0);
      end
    end
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 1'b0; m_tag[s][w] = 0; m_dat[s][w] = 0;
      end
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 idle after reset", int'({req_ready, rsp_valid}), 2);

    // R7 R1: empty ways with tag 0 never match
    for (int s = 0; s < SETS; s++) do_lookup(s, 0);

    // R8 install every line
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) do_fill(s, w, w + 1, line_data(s, w, w + 1));

    // R3 R4 R5 sweep: each line twice, the repeat must be fast
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        do_lookup(s, w + 1);
        do_lookup(s, w + 1);
        chk(m_pred[s] == w, "R5 model trained", m_pred[s], w);
      end

    // R6 misses leave the prediction: next access to the predicted way is fast
    for (int s = 0; s < SETS; s++) begin
      do_lookup(s, 9 + s);
      do_lookup(s, m_pred[s] + 1);
    end

    // R9 back-to-back predicted hits accepted every cycle
    for (int k = 0; k <= SETS; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(rsp_valid && rsp_fast && req_ready, "R9 streaming fast hit",
            int'({rsp_valid, rsp_fast, req_ready}), 7);
        chk(int'(rsp_data) == m_dat[k-1][m_pred[k-1]], "R9 streaming data",
            int'(rsp_data), m_dat[k-1][m_pred[k-1]]);
      end
      if (k < SETS) begin
        req_valid = 1'b1;
        req_addr = ADDR_W'(((m_pred[k] + 1) << IDX_W) | k);
      end else req_valid = 1'b0;
    end

    // R8 overwrite one line: old tag gone, new tag found, neighbours kept
    do_fill(2, 1, 12, line_data(2, 1, 12));
    do_lookup(2, 2);
    do_lookup(2, 12);
    do_lookup(2, 12);
    do_lookup(2, 1);
    do_lookup(1, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule